// File: doc/BRIEF.md
# Time Code Exchange Register

This block sits between a software register bank and a serial link that carries 8-bit time codes. One register word serves both directions. A software write can hand a code to the link transmitter, and a software read returns the last code the link receiver delivered. The address decode is done outside this block. It supplies a write strobe for the time code word and a write strobe for the status word, together with the shared write data.

A send request is held in a one-entry slot. The slot drives a valid/ready handshake toward the transmitter until the transmitter takes the code. Each code that arrives from the receiver is latched and sets a tick flag. The tick flag appears in the status word and, when enabled by a control bit held elsewhere, drives the interrupt line. Software clears the flag with a write-one-to-clear to the status word.

Top module: `timecode_port`

## Requirements
- R1: After reset, `tx_valid` is 0, the received code read through `tc_rdata[7:0]` is 0, and `tick` is 0.
- R2: A cycle with `tc_wr` high and `wdata[16]` = 1 makes `tx_valid` high in the next cycle, with `tx_code` equal to that cycle's `wdata[15:8]`.
- R3: A cycle with `tc_wr` high and `wdata[16]` = 0 changes neither `tx_valid` nor `tx_code`.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_code` stay unchanged. After a cycle with both high and no new request, `tx_valid` is low.
- R5: A request written while another is still pending replaces the pending code, and `tx_valid` stays high.
- R6: A cycle with `rx_valid` high puts `rx_code` on `tc_rdata[7:0]` from the next cycle on. `tc_rdata[31:8]` always reads 0.
- R7: A cycle with `rx_valid` high sets `tick` (status bit 10) in the next cycle.
- R8: A cycle with `st_wr` high and `wdata[10]` = 1 clears `tick` in the next cycle. `st_wr` with `wdata[10]` = 0 leaves `tick` unchanged. A code that arrives in the same cycle as a clear leaves `tick` set.
- R9: `irq` equals `tick` AND `tick_ie` in the same cycle, where `tick_ie` is the control register's bit 10.
- R10: A request written in the same cycle that the transmitter accepts the old code leaves `tx_valid` high with the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_wr | input | 1 | Write strobe for the time code word |
| st_wr | input | 1 | Write strobe for the status word |
| wdata | input | 32 | Shared register write data |
| tick_ie | input | 1 | Tick interrupt enable (control bit 10) |
| tc_rdata | output | 32 | Read value of the time code word |
| tick | output | 1 | Tick flag (status bit 10) |
| irq | output | 1 | Tick interrupt request |
| tx_valid | output | 1 | Code offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered code |
| tx_code | output | 8 | Code offered to the transmitter |
| rx_valid | input | 1 | Receiver delivers a code |
| rx_code | input | 8 | Code delivered by the receiver |

## Verification
Every registered result, meaning `tx_valid`, `tx_code`, `tc_rdata` and `tick`, is due exactly one clock edge after the write, handshake or arrival that causes it. `irq` follows `tick` and `tick_ie` in the same cycle with no register in between. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge from the inputs held across that edge. The comparison runs at the next falling edge, so each stimulus is judged one edge later, at the point where its effect is due. Directed sequences cover the same-cycle collisions: a request during an acceptance, and a clear during an arrival.

// File: rtl/timecode_port_pkg.sv
package timecode_port_pkg;
    localparam int REG_W     = 32;
    localparam int CODE_W    = 8;
    localparam int TXC_LSB   = 8;
    localparam int TXREQ_BIT = 16;
    localparam int TICK_BIT  = 10;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  pend;
        code_t code;
    } tx_state_t;

    typedef struct packed {
        logic  tick;
        code_t code;
    } rx_state_t;
endpackage

// File: rtl/timecode_tx_slot.sv
module timecode_tx_slot
    import timecode_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  code_t req_code,
    input  logic  ready,
    output logic  valid,
    output code_t code
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.pend = 1'b1;
            st_d.code = req_code;
        end else if (st_q.pend && ready) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.pend;
    assign code  = st_q.code;
endmodule

// File: rtl/timecode_rx_latch.sv
module timecode_rx_latch
    import timecode_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  arrive,
    input  code_t arrive_code,
    input  logic  clr,
    output logic  tick,
    output code_t code
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arrive) begin
            st_d.tick = 1'b1;
            st_d.code = arrive_code;
        end else if (clr) begin
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
    assign code = st_q.code;
endmodule

// File: rtl/timecode_port.sv
module timecode_port
    import timecode_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tc_wr,
    input  logic              st_wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              tick_ie,
    output logic [REG_W-1:0]  tc_rdata,
    output logic              tick,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CODE_W-1:0] tx_code,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_code
);
    logic  send_req;
    logic  tick_clr;
    code_t rx_last;

    assign send_req = tc_wr && wdata[TXREQ_BIT];
    assign tick_clr = st_wr && wdata[TICK_BIT];

    timecode_tx_slot u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (send_req),
        .req_code (wdata[TXC_LSB +: CODE_W]),
        .ready    (tx_ready),
        .valid    (tx_valid),
        .code     (tx_code)
    );

    timecode_rx_latch u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .arrive      (rx_valid),
        .arrive_code (rx_code),
        .clr         (tick_clr),
        .tick        (tick),
        .code        (rx_last)
    );

    assign tc_rdata = {{(REG_W-CODE_W){1'b0}}, rx_last};
    assign irq      = tick && tick_ie;
endmodule

// File: rtl/timecode_port_chk.sv
module timecode_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tc_wr,
    input logic        st_wr,
    input logic [31:0] wdata,
    input logic        tick_ie,
    input logic [31:0] tc_rdata,
    input logic        tick,
    input logic        irq,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_code,
    input logic        rx_valid,
    input logic [7:0]  rx_code
);
    // R2
    tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_wr && wdata[16]) |=> (tx_valid && tx_code == $past(wdata[15:8])));
    // R3
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tc_wr && wdata[16]) && !(tx_valid && tx_ready)) |=> ($stable(tx_valid) && $stable(tx_code)));
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);
    // R6
    rx_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (tc_rdata[7:0] == $past(rx_code)));
    // R7
    tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> tick);
    // R8
    tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata[10] && !rx_valid) |=> !tick);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || !tick_ie) |-> !irq);
endmodule

bind timecode_port timecode_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tc_wr(tc_wr), .st_wr(st_wr), .wdata(wdata),
    .tick_ie(tick_ie), .tc_rdata(tc_rdata), .tick(tick), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_code(tx_code),
    .rx_valid(rx_valid), .rx_code(rx_code)
);

// File: tb/timecode_port_test.sv
module timecode_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tc_wr = 1'b0, st_wr = 1'b0, tick_ie = 1'b0;
    logic [31:0] wdata = '0;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_code = '0;
    logic [31:0] tc_rdata;
    logic        tick, irq, tx_valid;
    logic [7:0]  tx_code;

    int n_run = 0, n_fail = 0;
    bit m_pend = 0, m_tick = 0;
    logic [7:0] m_txc = 0, m_rxc = 0;

    always #2 clk = ~clk;

    timecode_port uut (
        .clk(clk), .rst_n(rst_n), .tc_wr(tc_wr), .st_wr(st_wr), .wdata(wdata),
        .tick_ie(tick_ie), .tc_rdata(tc_rdata), .tick(tick), .irq(irq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_code(tx_code),
        .rx_valid(rx_valid), .rx_code(rx_code)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_tick = 0; m_txc = 0; m_rxc = 0;
        end else begin
            if (tc_wr && wdata[16]) begin
                m_pend = 1; m_txc = wdata[15:8];
            end else if (m_pend && tx_ready) m_pend = 0;
            if (rx_valid) begin
                m_tick = 1; m_rxc = rx_code;
            end else if (st_wr && wdata[10]) m_tick = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R2/R4 tx_valid", {31'b0, tx_valid}, {31'b0, m_pend});
        if (m_pend) chk("R5 tx_code", {24'b0, tx_code}, {24'b0, m_txc});
        chk("R6 tc_rdata", tc_rdata, {24'b0, m_rxc});
        chk("R7 tick", {31'b0, tick}, {31'b0, m_tick});
        chk("R9 irq", {31'b0, irq}, {31'b0, m_tick && tick_ie});
    endtask

    task automatic step();
        @(negedge clk);
        cmp_model();
        tc_wr = 0; st_wr = 0; rx_valid = 0; tx_ready = 0; wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("R1 tx_valid reset", {31'b0, tx_valid}, 0);
        chk("R1 rdata reset", tc_rdata, 0);
        chk("R1 tick reset", {31'b0, tick}, 0);
        // R3: write without request bit
        tc_wr = 1; wdata = 32'h0000_A500; step();
        chk("R3 no request", {31'b0, tx_valid}, 0);
        // R2: request
        tc_wr = 1; wdata = 32'h0001_3C00; step();
        chk("R2 valid", {31'b0, tx_valid}, 1);
        chk("R2 code", {24'b0, tx_code}, 32'h3C);
        // R4: hold without ready
        step(); step();
        chk("R4 hold", {24'b0, tx_code}, 32'h3C);
        // R3 while pending
        tc_wr = 1; wdata = 32'h0000_7700; step();
        chk("R3 code unchanged", {24'b0, tx_code}, 32'h3C);
        // R5: replace
        tc_wr = 1; wdata = 32'h0001_5A00; step();
        chk("R5 replace", {24'b0, tx_code}, 32'h5A);
        chk("R5 still valid", {31'b0, tx_valid}, 1);
        // R10: new request during accept
        tx_ready = 1; tc_wr = 1; wdata = 32'h0001_E100; step();
        chk("R10 valid", {31'b0, tx_valid}, 1);
        chk("R10 code", {24'b0, tx_code}, 32'hE1);
        // R4: accept
        tx_ready = 1; step();
        chk("R4 accept clears", {31'b0, tx_valid}, 0);
        // R6/R7 receive
        rx_valid = 1; rx_code = 8'h9D; step();
        chk("R6 rdata", tc_rdata, 32'h9D);
        chk("R7 tick", {31'b0, tick}, 1);
        chk("R9 irq off", {31'b0, irq}, 0);
        tick_ie = 1; step();
        chk("R9 irq on", {31'b0, irq}, 1);
        // R8: write zero bit10 ignored
        st_wr = 1; wdata = 32'hFFFF_FBFF; step();
        chk("R8 no clear", {31'b0, tick}, 1);
        // R8: clear
        st_wr = 1; wdata = 32'h0000_0400; step();
        chk("R8 clear", {31'b0, tick}, 0);
        chk("R9 irq drop", {31'b0, irq}, 0);
        // R8: set wins
        st_wr = 1; wdata = 32'h0000_0400; rx_valid = 1; rx_code = 8'h42; step();
        chk("R8 set wins", {31'b0, tick}, 1);
        chk("R6 second code", tc_rdata, 32'h42);
        // mixed traffic against the model
        for (int i = 0; i < 200; i++) begin
            tc_wr = (i % 3 == 0); st_wr = (i % 7 == 2);
            wdata = {15'b0, (i % 2 == 0), 8'(i * 37), 8'(i)} | ((i % 5 == 0) ? 32'h400 : 32'h0);
            tx_ready = (i % 4 == 1); rx_valid = (i % 6 == 3); rx_code = 8'(i * 11);
            tick_ie = (i % 9 < 5);
            @(negedge clk);
            cmp_model();
        end
        tc_wr = 0; st_wr = 0; rx_valid = 0; tx_ready = 0;
        // R1: reset mid-run
        tc_wr = 1; wdata = 32'h0001_1100; rx_valid = 1; rx_code = 8'h66; step();
        rst_n = 0; step(); rst_n = 1; step();
        chk("R1 valid after reset", {31'b0, tx_valid}, 0);
        chk("R1 rdata after reset", tc_rdata, 0);
        chk("R1 tick after reset", {31'b0, tick}, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule